// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores incoming frame bytes into memory buffers that software describes through a ring of two-word descriptors. Bytes arrive one per handshake with start and end markers. At the start of a frame the block reads the first word of the current descriptor. If that descriptor is free, the block packs the bytes little-endian into 32-bit words and writes them into the buffer. It then writes the status word and, one cycle later, sets the ownership bit in the first word. The walk moves to the next descriptor, or returns to the ring base when the descriptor carries the wrap flag.

A frame longer than one buffer continues into the following descriptors. A descriptor that still belongs to the engine, because software has not yet handed it back, is never overwritten. Instead the rest of the frame is discarded and a sticky overrun flag is raised. Software programs the block through a small write-only register port: a control word with the receive enable, the ring base, the buffer capacity and an overrun clear. The block reaches memory through a single word-wide port that serves both reads and writes.

Top module: `rxring_writer`

## Requirements
- R1: Writing the ring base (cfg_sel=1; bits 2:0 are ignored) sets the current descriptor to that address. Word 0 of a descriptor holds the buffer address in bits 31:2, the wrap flag in bit 1 and the engine-ownership flag in bit 0. The block reads word 0 when a frame start is pending.
- R2: Frame bytes go to consecutive buffer addresses from the buffer start, with byte k of a word in bits 8k+7:8k. Each write covers one word. mem_be bit k enables byte k, and a final partial word enables only its valid low bytes, with zero data in the unused lanes.
- R3: After a buffer is done, word 1 (descriptor address + 4) is written with the length in bits 13:0, the start-of-frame flag in bit 14 and the end-of-frame flag in bit 15. All other bits are zero.
- R4: In the cycle after the status write, word 0 is rewritten with the same buffer address and wrap flag and with bit 0 set to 1.
- R5: After the ownership write the current descriptor becomes descriptor address + 8. If the wrap flag was set, it becomes the ring base instead.
- R6: Buffer capacity is cfg_wdata[23:16] of a cfg_sel=2 write times 64 bytes, and the reset value is 0x18 (1536 bytes). A longer frame spans descriptors. Only the first carries the start flag and only the last carries the end flag. A non-last descriptor's length equals the capacity, and the last one's length is the whole frame length.
- R7: If a fetched descriptor has bit 0 set, nothing is written to it and the current descriptor does not advance. Every remaining byte of the frame is accepted and discarded up to its end marker, and the overrun flag is set.
- R8: The overrun flag stays set across later frames until a cfg_sel=3 write with bit 0 set clears it.
- R9: Reception requires the enable bit, bit 2 of a cfg_sel=0 write. While the block is idle and receive is off, arriving bytes are accepted and dropped with no memory access. A byte without a start marker is always dropped while idle.
- R10: After reset, receive is off, the overrun flag is 0, mem_req is 0, and in_ready is 1 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 ring base, 2 buffer size, 3 overrun clear |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid, any cycle after the request |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
The bench aims at frames that end exactly on a buffer boundary. If the end marker did not take precedence there, the design would close the buffer as non-last and fetch a spare descriptor. It also sends frames whose length leaves one byte in the last word, where wrong byte enables would corrupt memory next to the buffer. It runs a frame across the wrap descriptor, where a missed wrap sends the walk past the ring. It includes descriptors still owned by the engine, both at frame start and in the middle of a frame, where a faulty design would overwrite data software has not consumed, advance the pointer or forget the overrun flag. Disabled reception and stray bytes without a start marker must produce no memory traffic at all.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // Descriptor layout (fixed by software convention)
  localparam int DW        = 32;
  localparam int LEN_W     = 14;
  localparam int OWN_BIT   = 0;
  localparam int WRAP_BIT  = 1;
  localparam int SOF_BIT   = 14;
  localparam int EOF_BIT   = 15;
  localparam int LANES     = DW / 8;
  localparam int LANE_W    = $clog2(LANES);
  localparam int DESC_STEP = 8;

  // Register port
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_BASE  = 2'd1;
  localparam logic [1:0] SEL_BSIZE = 2'd2;
  localparam logic [1:0] SEL_CLR   = 2'd3;
  localparam int CTL_EN_BIT  = 2;
  localparam int BSIZE_LSB   = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_FILL, ST_STAT, ST_OWN, ST_DROP
  } rxr_state_e;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int UNIT_W    = 8,
  parameter int UNITS_RST = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              ovr_set,
  output logic              rx_en,
  output logic [DW-1:0]     ring_base,
  output logic              base_load,
  output logic [UNIT_W-1:0] buf_units,
  output logic              overrun
);
  logic              en_q, en_d;
  logic [DW-1:0]     base_q, base_d;
  logic              load_q, load_d;
  logic [UNIT_W-1:0] units_q, units_d;
  logic              ovr_q, ovr_d;
  logic              clr_hit;

  assign clr_hit = cfg_we && (cfg_sel == SEL_CLR) && cfg_wdata[0];

  always_comb begin
    en_d    = en_q;
    base_d  = base_q;
    units_d = units_q;
    load_d  = 1'b0;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_CTRL:  en_d = cfg_wdata[CTL_EN_BIT];
        SEL_BASE:  begin
          base_d = {cfg_wdata[DW-1:3], 3'b000};
          load_d = 1'b1;
        end
        SEL_BSIZE: units_d = cfg_wdata[BSIZE_LSB +: UNIT_W];
        default:   ;
      endcase
    end
    if (ovr_set)      ovr_d = 1'b1;
    else if (clr_hit) ovr_d = 1'b0;
    else              ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      base_q  <= '0;
      load_q  <= 1'b0;
      units_q <= UNIT_W'(UNITS_RST);
      ovr_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      base_q  <= base_d;
      load_q  <= load_d;
      units_q <= units_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rx_en     = en_q;
  assign ring_base = base_q;
  assign base_load = load_q;
  assign buf_units = units_q;
  assign overrun   = ovr_q;

  // R8: flag holds until an explicit clear
  a_r8_sticky_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_hit) |=> ovr_q);
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              flush,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        byte_in,
  output logic [DW-1:0]     word,
  output logic [LANES-1:0]  be
);
  logic [DW-1:0]    acc_q, acc_d;
  logic [LANES-1:0] bq, bd;

  always_comb begin
    word = acc_q;
    be   = bq;
    for (int k = 0; k < LANES; k++) begin
      if (lane == LANE_W'(k)) begin
        word[k*8 +: 8] = byte_in;
        be[k]          = 1'b1;
      end
    end
    acc_d = acc_q;
    bd    = bq;
    if (take) begin
      if (flush) begin
        acc_d = '0;
        bd    = '0;
      end else begin
        acc_d = word;
        bd    = be;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bq    <= '0;
    end else if (take) begin
      acc_q <= acc_d;
      bq    <= bd;
    end
  end

  // R2: enables always form a run starting at lane 0
  a_r2_be_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (take && flush) |-> (((be + LANES'(1)) & be) == '0));
endmodule

// File: rtl/rxr_walker.sv
module rxr_walker
  import rxr_pkg::*;
#(
  parameter int UNIT_W     = 8,
  parameter int UNIT_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [DW-1:0]     ring_base,
  input  logic              base_load,
  input  logic [UNIT_W-1:0] buf_units,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              take,
  output logic              flush,
  output logic [LANE_W-1:0] lane,
  input  logic [DW-1:0]     pk_word,
  input  logic [LANES-1:0]  pk_be,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [LANES-1:0]  mem_be,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_rvalid,
  output logic              ovr_set
);
  localparam int CNT_W = LEN_W + 1;

  rxr_state_e       st_q, st_d;
  logic [DW-1:0]    ptr_q, ptr_d;
  logic [DW-3:0]    bufa_q, bufa_d;
  logic             wrap_q, wrap_d;
  logic [LEN_W-1:0] boff_q, boff_d;
  logic [LEN_W-1:0] flen_q, flen_d;
  logic [LEN_W-1:0] slen_q, slen_d;
  logic             first_q, first_d;
  logic             last_q, last_d;

  logic [CNT_W-1:0] cap, boff_inc;
  logic             buf_end, start_hit;
  logic [DW-1:0]    stat_word;

  assign cap       = CNT_W'(buf_units) << UNIT_SHIFT;
  assign boff_inc  = {1'b0, boff_q} + CNT_W'(1);
  assign buf_end   = (boff_inc == cap);
  assign lane      = boff_q[LANE_W-1:0];
  assign start_hit = rx_en && in_valid && in_sof;

  always_comb begin
    stat_word                = '0;
    stat_word[LEN_W-1:0]     = slen_q;
    stat_word[SOF_BIT]       = first_q;
    stat_word[EOF_BIT]       = last_q;
  end

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    bufa_d    = bufa_q;
    wrap_d    = wrap_q;
    boff_d    = boff_q;
    flen_d    = flen_q;
    slen_d    = slen_q;
    first_d   = first_q;
    last_d    = last_q;
    in_ready  = 1'b0;
    take      = 1'b0;
    flush     = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = '0;
    mem_be    = '0;
    ovr_set   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        in_ready = !start_hit;
        if (start_hit) begin
          st_d    = ST_FETCH;
          flen_d  = '0;
          first_d = 1'b1;
        end
      end
      ST_FETCH: begin
        mem_req = 1'b1;
        st_d    = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rvalid) begin
          if (mem_rdata[OWN_BIT]) begin
            ovr_set = 1'b1;
            st_d    = ST_DROP;
          end else begin
            bufa_d = mem_rdata[DW-1:2];
            wrap_d = mem_rdata[WRAP_BIT];
            boff_d = '0;
            st_d   = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        in_ready = 1'b1;
        if (in_valid) begin
          take   = 1'b1;
          flush  = in_eof || buf_end || (lane == LANE_W'(LANES - 1));
          boff_d = boff_inc[LEN_W-1:0];
          flen_d = flen_q + LEN_W'(1);
          if (flush) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {bufa_q, 2'b00} + DW'({boff_q[LEN_W-1:2], 2'b00});
            mem_wdata = pk_word;
            mem_be    = pk_be;
          end
          if (in_eof || buf_end) begin
            last_d = in_eof;
            slen_d = in_eof ? flen_q + LEN_W'(1) : boff_inc[LEN_W-1:0];
            st_d   = ST_STAT;
          end
        end
      end
      ST_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + DW'(4);
        mem_wdata = stat_word;
        mem_be    = '1;
        st_d      = ST_OWN;
      end
      ST_OWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {bufa_q, wrap_q, 1'b1};
        mem_be    = '1;
        ptr_d     = wrap_q ? ring_base : ptr_q + DW'(DESC_STEP);
        first_d   = 1'b0;
        st_d      = last_q ? ST_IDLE : ST_FETCH;
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_eof) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (base_load) ptr_d = ring_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      bufa_q  <= '0;
      wrap_q  <= 1'b0;
      boff_q  <= '0;
      flen_q  <= '0;
      slen_q  <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      bufa_q  <= bufa_d;
      wrap_q  <= wrap_d;
      boff_q  <= boff_d;
      flen_q  <= flen_d;
      slen_q  <= slen_d;
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

  // R3: ownership write is preceded by the status write of the same descriptor
  a_r3_status_before_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OWN) |-> ($past(mem_we) && ($past(mem_addr) == mem_addr + DW'(4))));
  // R9: no memory traffic while idle with receive off
  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !rx_en) |-> !mem_req);
  // R7: a rejected frame drains without touching memory
  a_r7_drop_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |-> (in_ready && !mem_req));
  // R6: data writes stay inside the buffer capacity
  a_r6_fill_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && mem_we) |-> ({1'b0, boff_q} < cap));
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxr_pkg::*;
#(
  parameter int UNIT_W     = 8,
  parameter int UNIT_SHIFT = 6,
  parameter int UNITS_RST  = 8'h18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rvalid,
  output logic        rx_overrun
);
  logic              rx_en, base_load, ovr_set;
  logic [DW-1:0]     ring_base;
  logic [UNIT_W-1:0] buf_units;
  logic              take, flush;
  logic [LANE_W-1:0] lane;
  logic [DW-1:0]     pk_word;
  logic [LANES-1:0]  pk_be;

  rxr_regs #(.UNIT_W(UNIT_W), .UNITS_RST(UNITS_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ovr_set(ovr_set), .rx_en(rx_en),
    .ring_base(ring_base), .base_load(base_load), .buf_units(buf_units),
    .overrun(rx_overrun)
  );

  rxr_packer u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .flush(flush), .lane(lane),
    .byte_in(in_data), .word(pk_word), .be(pk_be)
  );

  rxr_walker #(.UNIT_W(UNIT_W), .UNIT_SHIFT(UNIT_SHIFT)) u_walk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .base_load(base_load), .buf_units(buf_units), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready), .take(take),
    .flush(flush), .lane(lane), .pk_word(pk_word), .pk_be(pk_be),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .ovr_set(ovr_set)
  );
endmodule

// File: tb/rxring_writer_tb_top.sv
`timescale 1ns/1ps
module rxring_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic        rx_overrun;

  int n_vec = 0;
  int n_fail = 0;

  logic [31:0] mem     [0:1023];
  logic [31:0] ref_mem [0:1023];
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  logic [3:0]  q_be[$];
  string       q_tag[$];
  logic [31:0] ref_ptr = '0, ref_base = '0;
  int          ref_units = 24;
  bit          ref_en = 1'b0;
  bit          ovr_exp = 1'b0;

  always #2.5 clk = ~clk;

  rxring_writer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .rx_overrun(rx_overrun)
  );

  // Memory model: reads answer one cycle later, writes honour byte enables
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem[mem_addr[11:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
      end else begin
        mem_rdata  <= mem[mem_addr[11:2]];
        mem_rvalid <= 1'b1;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every clock: each memory write must match the next predicted one
  always @(negedge clk) begin
    #2;
    if (rst_n && mem_req && mem_we) begin
      if (q_addr.size() == 0) begin
        n_vec++; n_fail++;
        $display("FAIL R9 actual=unexpected write %h@%h expected=no write", mem_wdata, mem_addr);
      end else begin
        check({q_tag[0], " addr"}, mem_addr, q_addr[0]);
        check({q_tag[0], " data"}, mem_wdata, q_data[0]);
        check({q_tag[0], " be"}, {28'd0, mem_be}, {28'd0, q_be[0]});
        void'(q_addr.pop_front()); void'(q_data.pop_front());
        void'(q_be.pop_front());   void'(q_tag.pop_front());
      end
    end
  end

  function automatic logic [7:0] bval(int id, int i);
    return 8'(id * 37 + i * 5 + 1);
  endfunction

  function automatic void expect_wr(logic [31:0] a, logic [31:0] d, logic [3:0] b, string t);
    q_addr.push_back(a); q_data.push_back(d); q_be.push_back(b); q_tag.push_back(t);
  endfunction

  // Behavioural reference: walks its own copy of the ring
  function automatic void predict(int len, int id);
    int off = 0;
    bit first = 1'b1;
    if (!ref_en) return;
    while (off < len) begin
      logic [31:0] d0 = ref_mem[ref_ptr[11:2]];
      logic [31:0] ba, sw;
      int cap, n;
      bit last;
      if (d0[0]) begin ovr_exp = 1'b1; return; end
      ba  = {d0[31:2], 2'b00};
      cap = ref_units * 64;
      n   = (len - off < cap) ? len - off : cap;
      for (int j = 0; j * 4 < n; j++) begin
        logic [31:0] w = '0;
        logic [3:0]  b = '0;
        for (int k = 0; k < 4; k++)
          if (j * 4 + k < n) begin
            w[k*8 +: 8] = bval(id, off + j * 4 + k);
            b[k] = 1'b1;
          end
        expect_wr(ba + 32'(j * 4), w, b, "R2");
      end
      last = (off + n == len);
      sw = '0;
      sw[13:0] = 14'(last ? len : n);
      sw[14] = first;
      sw[15] = last;
      expect_wr(ref_ptr + 4, sw, 4'hF, "R3 R6");
      expect_wr(ref_ptr, d0 | 32'd1, 4'hF, "R1 R4 R5");
      ref_mem[ref_ptr[11:2]] = d0 | 32'd1;
      ref_mem[ref_ptr[11:2] + 1] = sw;
      ref_ptr = d0[1] ? ref_base : ref_ptr + 8;
      off += n;
      first = 1'b0;
    end
  endfunction

  task automatic cfg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_desc(int idx, logic [31:0] ba, bit wrap);
    int w = int'(ref_base[11:2]) + 2 * idx;
    mem[w] = ba | (wrap ? 32'd2 : 32'd0); mem[w + 1] = '0;
    ref_mem[w] = mem[w]; ref_mem[w + 1] = '0;
  endtask

  task automatic release_desc(int idx);
    int w = int'(ref_base[11:2]) + 2 * idx;
    mem[w][0] = 1'b0; ref_mem[w][0] = 1'b0;
  endtask

  task automatic send(int len, int id, bit with_sof);
    predict(with_sof ? len : 0, id);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = bval(id, i);
      in_sof = with_sof && (i == 0); in_eof = (i == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 R8 overrun", {31'd0, rx_overrun}, {31'd0, ovr_exp});
    check("R3 pending writes", 32'(q_addr.size()), 32'd0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R10 in_ready", {31'd0, in_ready}, 32'd1);
    check("R10 mem_req", {31'd0, mem_req}, 32'd0);
    check("R10 overrun", {31'd0, rx_overrun}, 32'd0);

    // Ring of four descriptors at 0x100, last one wraps
    cfg(2'd1, 32'h0000_0105);              // R1: low bits dropped
    ref_base = 32'h100; ref_ptr = 32'h100;
    set_desc(0, 32'h400, 1'b0); set_desc(1, 32'h600, 1'b0);
    set_desc(2, 32'h800, 1'b0); set_desc(3, 32'hA00, 1'b1);

    // R9: receive off, frame is swallowed with no traffic
    @(negedge clk); in_valid = 1'b1; in_sof = 1'b1; #1;
    check("R9 ready while off", {31'd0, in_ready}, 32'd1);
    send(10, 1, 1'b1);

    cfg(2'd0, 32'h4); ref_en = 1'b1;
    send(100, 2, 1'b1);                     // R6 default capacity 1536
    cfg(2'd2, 32'h0001_0000); ref_units = 1; // 64-byte buffers
    send(13, 3, 1'b1);                      // R2 partial last word
    release_desc(0);
    send(150, 4, 1'b1);                     // R5 wrap, R6 spanning
    send(20, 5, 1'b1);                      // R7 owned at frame start
    release_desc(1);
    send(4, 6, 1'b1);                       // R8 flag stays
    cfg(2'd3, 32'h1); ovr_exp = 1'b0;
    check("R8 cleared", {31'd0, rx_overrun}, 32'd0);
    release_desc(2);
    send(100, 7, 1'b1);                     // R7 owned mid-frame
    cfg(2'd3, 32'h1); ovr_exp = 1'b0;
    release_desc(3);
    send(64, 8, 1'b1);                      // R6 end exactly at capacity
    send(6, 9, 1'b0);                       // R9 stray bytes without start
    release_desc(0);
    send(5, 10, 1'b1);                      // R5 after wrap back at base

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule